// File: doc/BRIEF.md
# Tagged-Lane Reduction Unit

This block adds up the product fields of a bank of processing lanes. Only the lanes whose tag bit is set count toward the total. Each request carries an opaque label, typically the row and column of the result element being formed. The unit returns one labelled sum for every request it accepts. The tagged lanes of one request all hold partial products of the same output element.

The unit has two datapaths, and a static mode input picks between them.

- **Tree mode** masks the untagged lanes to zero and feeds all lanes into a registered binary adder tree. It accepts a request on every cycle and returns each sum after a fixed latency. This suits groups that contain many products.
- **Serial mode** captures the lane bank and the tag mask when a request is accepted. It then repeatedly picks the lowest remaining tagged lane, adds it to a running sum and clears its tag. It consumes one tagged lane per cycle, which suits groups that contain only a few products. While a serial reduction runs, the unit refuses new requests.

In both modes results leave in the order the requests were accepted.

Top module: `tag_reduce`

## Requirements
- R1: The result equals the exact signed sum of the 16-bit two's-complement products of all tagged lanes. The result is SUM_W = 20 bits wide, so it cannot overflow. Lane i occupies bits [16*i+15:16*i] of prod_i, and tag_i[i] selects lane i.
- R2: An untagged lane contributes nothing to the result, whatever its product value. An all-zero tag mask yields a sum of 0.
- R3: In tree mode (serial_mode_i = 0), a request accepted at clock edge A produces res_valid_o high after edge A+4-1 (A+3), with its sum and label.
- R4: In tree mode ready_o stays high, so a new request is accepted every cycle. Back-to-back requests produce results on consecutive cycles.
- R5: In serial mode (serial_mode_i = 1), a request with n ≥ 1 tagged lanes, accepted at edge A, produces its result after edge A+n. Each busy cycle retires exactly one tagged lane.
- R6: In serial mode a request with an all-zero tag mask produces a sum of 0 after edge A+1.
- R7: In serial mode ready_o is low from the cycle after acceptance until the result is produced. A start_i asserted while ready_o is low is ignored and produces no result.
- R8: In serial mode the products, tags and label are captured at acceptance. Later changes on prod_i, tag_i or label_i do not affect that request's result.
- R9: Each accepted request yields exactly one single-cycle res_valid_o pulse. Results leave in acceptance order, carrying the label given with the request.
- R10: While rst_ni is low, and right after reset, res_valid_o is 0 and ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| serial_mode_i | input | 1 | Static mode select: 0 selects the adder tree, 1 selects the serial scan |
| start_i | input | 1 | Reduction request; taken when ready_o is high |
| label_i | input | 16 | Label of the result element, returned with the sum |
| prod_i | input | 256 | Sixteen signed 16-bit lane products, lane i at bits [16*i+15:16*i] |
| tag_i | input | 16 | Per-lane tag; bit i enables lane i |
| ready_o | output | 1 | High when a request can be accepted |
| res_valid_o | output | 1 | One-cycle pulse marking a result |
| res_label_o | output | 16 | Label of the current result |
| res_sum_o | output | 20 | Signed sum of the tagged lanes |

## Verification
The embedded properties watch several behaviours on every cycle:

- an all-untagged request leaves zeros in the first tree level;
- each serial busy cycle removes exactly one tag;
- a serial request with an empty mask finishes on the next cycle;
- no serial result appears directly after acceptance;
- an accepted serial request drops ready_o.

Other behaviours can only be shown by the bench's scenarios. These are the exact sum values, including the extreme negative and positive totals; the cycle on which each result appears in each mode; the order and labels of back-to-back results; the isolation of a captured serial request from later input changes; and the absence of a result for a start that was refused.

// File: rtl/tag_reduce_pkg.sv
package tag_reduce_pkg;
  typedef enum logic {
    MODE_TREE   = 1'b0,
    MODE_SERIAL = 1'b1
  } mode_e;
endpackage

// File: rtl/tag_reduce_tree.sv
module tag_reduce_tree #(
  parameter int LANES  = 16,
  parameter int PROD_W = 16,
  parameter int SUM_W  = 20,
  parameter int LBL_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  input  logic [LBL_W-1:0]        label_i,
  input  logic [LANES*PROD_W-1:0] prod_i,
  input  logic [LANES-1:0]        tag_i,
  output logic                    out_valid_o,
  output logic [LBL_W-1:0]        out_label_o,
  output logic signed [SUM_W-1:0] out_sum_o
);
  localparam int STAGES = $clog2(LANES);
  localparam int NODES  = LANES - 1;
  localparam int FIRST  = LANES/2 - 1;  // first node fed by leaves

  logic signed [SUM_W-1:0] leaf [LANES];
  logic signed [SUM_W-1:0] node [NODES];
  logic [STAGES-1:0]       vld_q;
  logic [LBL_W-1:0]        lbl_q [STAGES];

  // masked, sign-extended leaves
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [PROD_W-1:0] p;
      p = prod_i[i*PROD_W +: PROD_W];
      leaf[i] = tag_i[i] ? {{(SUM_W-PROD_W){p[PROD_W-1]}}, p} : '0;
    end
  end

  // heap layout: node n has children 2n+1 and 2n+2
  for (genvar n = 0; n < NODES; n++) begin : g_node
    if (n >= FIRST) begin : g_leafsum
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) node[n] <= '0;
        else         node[n] <= leaf[2*n+1-NODES] + leaf[2*n+2-NODES];
    end else begin : g_nodesum
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) node[n] <= '0;
        else         node[n] <= node[2*n+1] + node[2*n+2];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < STAGES; s++) lbl_q[s] <= '0;
    end else begin
      vld_q[0] <= in_valid_i;
      lbl_q[0] <= label_i;
      for (int s = 1; s < STAGES; s++) begin
        vld_q[s] <= vld_q[s-1];
        lbl_q[s] <= lbl_q[s-1];
      end
    end
  end

  assign out_valid_o = vld_q[STAGES-1];
  assign out_label_o = lbl_q[STAGES-1];
  assign out_sum_o   = node[0];

  logic lvl1_zero;
  always_comb begin
    lvl1_zero = 1'b1;
    for (int n = FIRST; n < NODES; n++)
      if (node[n] != '0) lvl1_zero = 1'b0;
  end

  AST_UNTAGGED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && tag_i == '0) |=> lvl1_zero); // R2
endmodule

// File: rtl/tag_reduce_serial.sv
module tag_reduce_serial #(
  parameter int LANES  = 16,
  parameter int PROD_W = 16,
  parameter int SUM_W  = 20,
  parameter int LBL_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [LBL_W-1:0]        label_i,
  input  logic [LANES*PROD_W-1:0] prod_i,
  input  logic [LANES-1:0]        tag_i,
  output logic                    busy_o,
  output logic                    out_valid_o,
  output logic [LBL_W-1:0]        out_label_o,
  output logic signed [SUM_W-1:0] out_sum_o
);
  localparam int IDX_W = $clog2(LANES);

  logic                    busy_q, vld_q;
  logic [LANES-1:0]        mask_q, mask_nxt;
  logic [LANES*PROD_W-1:0] prod_q;
  logic signed [SUM_W-1:0] acc_q, acc_nxt, sum_q;
  logic [LBL_W-1:0]        lbl_q;
  logic [IDX_W-1:0]        idx;
  logic [PROD_W-1:0]       pick;

  // lowest set bit of remaining mask
  always_comb begin
    idx = '0;
    for (int i = LANES-1; i >= 0; i--)
      if (mask_q[i]) idx = IDX_W'(i);
  end

  always_comb begin
    pick     = prod_q[idx*PROD_W +: PROD_W];
    mask_nxt = mask_q;
    acc_nxt  = acc_q;
    if (mask_q != '0) begin
      mask_nxt[idx] = 1'b0;
      acc_nxt = acc_q + {{(SUM_W-PROD_W){pick[PROD_W-1]}}, pick};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      mask_q <= '0;
      prod_q <= '0;
      acc_q  <= '0;
      sum_q  <= '0;
      lbl_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        mask_q <= tag_i;
        prod_q <= prod_i;
        acc_q  <= '0;
        lbl_q  <= label_i;
      end else if (busy_q) begin
        mask_q <= mask_nxt;
        acc_q  <= acc_nxt;
        if (mask_nxt == '0) begin
          busy_q <= 1'b0;
          vld_q  <= 1'b1;
          sum_q  <= acc_nxt;
        end
      end
    end
  end

  assign busy_o      = busy_q;
  assign out_valid_o = vld_q;
  assign out_label_o = lbl_q;
  assign out_sum_o   = sum_q;

  AST_ONE_LANE_PER_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && mask_q != '0) |=> ($countones(mask_q) == $countones($past(mask_q)) - 1)); // R5
  AST_EMPTY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && mask_q == '0) |=> (out_valid_o && out_sum_o == '0)); // R6
  AST_NO_EARLY_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !out_valid_o); // R5
endmodule

// File: rtl/tag_reduce.sv
module tag_reduce
  import tag_reduce_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int PROD_W = 16,
  parameter int SUM_W  = PROD_W + $clog2(LANES),
  parameter int LBL_W  = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    serial_mode_i,
  input  logic                    start_i,
  input  logic [LBL_W-1:0]        label_i,
  input  logic [LANES*PROD_W-1:0] prod_i,
  input  logic [LANES-1:0]        tag_i,
  output logic                    ready_o,
  output logic                    res_valid_o,
  output logic [LBL_W-1:0]        res_label_o,
  output logic [SUM_W-1:0]        res_sum_o
);
  mode_e mode;
  logic  tree_go, ser_go, ser_busy;
  logic  tree_vld, ser_vld;
  logic [LBL_W-1:0]        tree_lbl, ser_lbl;
  logic signed [SUM_W-1:0] tree_sum, ser_sum;

  assign mode    = mode_e'(serial_mode_i);
  assign ready_o = !(mode == MODE_SERIAL && ser_busy);
  assign tree_go = start_i && mode == MODE_TREE;
  assign ser_go  = start_i && mode == MODE_SERIAL && !ser_busy;

  tag_reduce_tree #(
    .LANES(LANES), .PROD_W(PROD_W), .SUM_W(SUM_W), .LBL_W(LBL_W)
  ) u_tree (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (tree_go),
    .label_i     (label_i),
    .prod_i      (prod_i),
    .tag_i       (tag_i),
    .out_valid_o (tree_vld),
    .out_label_o (tree_lbl),
    .out_sum_o   (tree_sum)
  );

  tag_reduce_serial #(
    .LANES(LANES), .PROD_W(PROD_W), .SUM_W(SUM_W), .LBL_W(LBL_W)
  ) u_serial (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (ser_go),
    .label_i     (label_i),
    .prod_i      (prod_i),
    .tag_i       (tag_i),
    .busy_o      (ser_busy),
    .out_valid_o (ser_vld),
    .out_label_o (ser_lbl),
    .out_sum_o   (ser_sum)
  );

  assign res_valid_o = (mode == MODE_SERIAL) ? ser_vld : tree_vld;
  assign res_label_o = (mode == MODE_SERIAL) ? ser_lbl : tree_lbl;
  assign res_sum_o   = (mode == MODE_SERIAL) ? ser_sum : tree_sum;

  AST_REFUSE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_mode_i && start_i && ready_o) |=> !ready_o); // R7
  AST_SERIAL_QUIET_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (serial_mode_i && !ready_o && $stable(serial_mode_i)) |-> !res_valid_o); // R9
endmodule

// File: tb/tag_reduce_bench.sv
`timescale 1ns/1ps
module tag_reduce_bench;
  localparam int LANES = 16;
  localparam int PW    = 16;
  localparam int SW    = 20;
  localparam int LW    = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic serial_mode, start;
  logic [LW-1:0]       label;
  logic [LANES*PW-1:0] prod;
  logic [LANES-1:0]    tag;
  logic ready, res_valid;
  logic [LW-1:0] res_label;
  logic [SW-1:0] res_sum;

  logic signed [PW-1:0] lane [LANES];

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < LANES; i++) prod[i*PW +: PW] = lane[i];

  tag_reduce u_tag_reduce (
    .clk_i(clk), .rst_ni(rst_n), .serial_mode_i(serial_mode), .start_i(start),
    .label_i(label), .prod_i(prod), .tag_i(tag), .ready_o(ready),
    .res_valid_o(res_valid), .res_label_o(res_label), .res_sum_o(res_sum)
  );

  typedef struct {
    logic [LW-1:0]        lbl;
    logic signed [SW-1:0] sum;
    int                   cyc;
    string                rsum;
    string                rtime;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_chk = 0, n_fail = 0, n_res = 0, n_issued = 0, n_unexp = 0;
  logic [31:0] seed = 32'h1234_5678;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic signed [SW-1:0] ref_sum();
    logic signed [SW-1:0] s = '0;
    for (int i = 0; i < LANES; i++)
      if (tag[i]) s = s + lane[i];
    return s;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      n_res++;
      if (sb.size() == 0) begin
        n_unexp++;
        chk(1'b0, "R9", "unexpected result label", res_label, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk($signed(res_sum) == e.sum, e.rsum, "sum", $signed(res_sum), e.sum);
        chk(res_label == e.lbl, "R9", "label", res_label, e.lbl);
        chk(cyc == e.cyc, e.rtime, "result cycle", cyc, e.cyc);
      end
    end
  end

  // called at a negedge with lanes/tag set; leaves start high
  task automatic issue(input logic [LW-1:0] l, input string rsum);
    exp_t e;
    int n, lat;
    n = $countones(tag);
    if (serial_mode) begin
      while (!ready) @(negedge clk);
      lat = (n == 0) ? 1 : n;
      e.rtime = (n == 0) ? "R6" : "R5";
    end else begin
      lat = 3;
      e.rtime = "R3";
    end
    label  = l;
    start  = 1'b1;
    e.lbl  = l;
    e.sum  = ref_sum();
    e.cyc  = cyc + 1 + lat;
    e.rsum = rsum;
    sb.push_back(e);
    n_issued++;
    @(negedge clk);
  endtask

  task automatic fill_rnd();
    for (int i = 0; i < LANES; i++) lane[i] = PW'(rnd());
    tag = LANES'(rnd());
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", sb.size());
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    serial_mode = 1'b0;
    start = 1'b0;
    label = '0;
    tag = '0;
    for (int i = 0; i < LANES; i++) lane[i] = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R10", "valid in reset", res_valid, 0);
    chk(ready == 1'b1, "R10", "ready in reset", ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R10", "ready after reset", ready, 1);

    // tree: extremes
    for (int i = 0; i < LANES; i++) lane[i] = -16'sd32768;
    tag = '1;
    issue(16'h0101, "R1");
    for (int i = 0; i < LANES; i++) lane[i] = 16'sd32767;
    issue(16'h0102, "R1");
    // tree: large untagged values, empty mask
    tag = '0;
    issue(16'h0103, "R2");
    tag = 16'h0005;
    for (int i = 0; i < LANES; i++) lane[i] = 16'sd1000 + 16'(i);
    lane[1] = 16'sd32767;
    lane[3] = -16'sd32768;
    issue(16'h0104, "R2");
    // tree: back-to-back random
    for (int k = 0; k < 12; k++) begin
      fill_rnd();
      chk(ready == 1'b1, "R4", "tree ready", ready, 1);
      issue(16'h0200 + 16'(k), "R4");
    end
    start = 1'b0;
    drain();

    // serial mode
    serial_mode = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R10", "serial idle ready", ready, 1);
    for (int i = 0; i < LANES; i++) lane[i] = 16'(i*100 - 700);
    tag = 16'h0124;
    issue(16'h0301, "R5");
    start = 1'b0;
    drain();
    tag = 16'h8000;
    issue(16'h0302, "R5");
    start = 1'b0;
    drain();
    tag = '0;
    issue(16'h0303, "R6");
    start = 1'b0;
    drain();
    for (int i = 0; i < LANES; i++) lane[i] = -16'sd32768;
    tag = '1;
    issue(16'h0304, "R1");
    start = 1'b0;
    drain();

    // captured inputs: scramble after acceptance
    fill_rnd();
    tag = 16'h0f0c;
    issue(16'h0305, "R8");
    start = 1'b0;
    for (int i = 0; i < LANES; i++) lane[i] = 16'sd32767;
    tag = '1;
    label = 16'hffff;
    drain();

    // refused start while busy
    fill_rnd();
    tag = 16'h001f;
    issue(16'h0306, "R7");
    chk(ready == 1'b0, "R7", "ready while busy", ready, 0);
    label = 16'hbad0;
    tag = '1;
    @(negedge clk);
    chk(ready == 1'b0, "R7", "ready still low", ready, 0);
    @(negedge clk);
    start = 1'b0;
    drain();
    chk(n_unexp == 0, "R7", "results from refused start", n_unexp, 0);

    // serial back-to-back through ready
    for (int k = 0; k < 6; k++) begin
      fill_rnd();
      tag = tag & 16'h0303;
      issue(16'h0400 + 16'(k), "R5");
    end
    start = 1'b0;
    drain();

    chk(n_res == n_issued, "R9", "result count", n_res, n_issued);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule